// File: doc/BRIEF.md
# Payload-Extended Acceptance Filter Bank

This block decides whether a received standard-identifier CAN frame is accepted. It holds a bank of acceptance filters, and each filter stores an 11-bit identifier and an 18-bit payload pattern. When a frame is presented with a one-cycle valid strobe, every enabled filter compares the frame identifier. It also compares a leading run of payload bits taken from the first three data bytes. One cycle later the block reports whether any filter matched, and the number of the lowest matching filter.

Two limits set how many payload bits take part, and the smaller one wins. The first is a shared 5-bit length count held in a register. The second is the frame's own data length code, since a frame carrying one byte cannot supply more than 8 bits. No more than 18 bits are ever compared. A legacy-mode input forces the count to zero, so that only the identifier is used. Software programs the enables, the count and the filter patterns through a simple write port and a combinational read port. The count and the patterns can change only while a configuration-mode input is high.

Top module: `can_payload_filter_bank`

## Requirements
- R1: There are 16 filters. The enable register sits at address 0x00, with bit n enabling filter n, and it resets to 0x0003. It can be written at any time. A filter whose enable bit is 0 never produces a hit.
- R2: A filter can hit only when the frame identifier equals the filter's stored identifier in all 11 bits.
- R3: The number of payload bits compared is L = min(count, 8 x min(DLC, 3), 18). When DLC is 0, L is 0 and only the identifier decides. A count above 18 behaves as 18.
- R4: The payload window is {byte0, byte1, byte2[7:6]}, with byte 0 in frm_data[23:16] and byte 2 in frm_data[7:0]. The top L window bits are compared against filter pattern bits L-1..0. Byte 0 bit 7 faces pattern bit L-1, and all lower window bits are ignored.
- R5: The length-count register sits at address 0x01 and resets to 0. It holds 5 bits, and read bits 31:5 are always 0.
- R6: Filter n's register sits at address 0x10+n, with the identifier in bits 28:18 and the pattern in bits 17:0. It reads back in the same layout and resets to 0. Writes to this register and to the length count take effect only while cfg_mode is 1. At other times they leave the stored value and the filtering unchanged.
- R7: While legacy_mode is 1, the count reads as 0 and L is 0. The stored count returns when legacy_mode goes back to 0.
- R8: flt_hit and flt_idx update on the clock edge where frm_valid is 1, so they are visible the cycle after the strobe. At other times they hold. When several filters match, the lowest number is reported, and flt_idx is 0 on a miss.
- R9: After reset, flt_hit and flt_idx are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_mode | input | 1 | Permits writes to the count and filter registers |
| legacy_mode | input | 1 | Forces the compare length to zero |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 6 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| frm_valid | input | 1 | Frame present this cycle |
| frm_id | input | 11 | Frame standard identifier |
| frm_dlc | input | 4 | Frame data length code |
| frm_data | input | 24 | Data bytes 0..2, byte 0 in the top bits |
| flt_hit | output | 1 | Some enabled filter matched |
| flt_idx | output | 4 | Lowest matching filter number |

## Verification
The bench builds the block with its default parameters: 16 filters, an 18-bit payload window and a 5-bit count. With these values every DLC class can be reached, from zero bits through the 8- and 16-bit caps to the 18-bit ceiling. A count value of 31 exercises saturation, and a filter number as high as 9 exercises the priority order. The vectors place differing bits both just inside and just outside the compared window, so an off-by-one in the alignment or the mask changes the result.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] ADDR_EN  = 6'h00;
    localparam logic [ADDR_W-1:0] ADDR_CNT = 6'h01;
    localparam logic [1:0]        FLT_PAGE = 2'b01;
endpackage

// File: rtl/cfl_regs.sv
module cfl_regs
    import cfl_pkg::*;
#(
    parameter int NUM_FILT = 16,
    parameter int ID_W     = 11,
    parameter int WIN_W    = 18,
    parameter int CNT_W    = 5,
    parameter logic [NUM_FILT-1:0] EN_RESET = 16'h0003
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_mode,
    input  logic                                legacy_mode,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   rd_data,
    output logic [NUM_FILT-1:0]                 en_vec,
    output logic [CNT_W-1:0]                    cnt_raw,
    output logic [CNT_W-1:0]                    cnt_eff,
    output logic [NUM_FILT-1:0][ID_W-1:0]       fid,
    output logic [NUM_FILT-1:0][WIN_W-1:0]      fval
);
    typedef struct packed {
        logic [NUM_FILT-1:0]            en;
        logic [CNT_W-1:0]               cnt;
        logic [NUM_FILT-1:0][ID_W-1:0]  fid;
        logic [NUM_FILT-1:0][WIN_W-1:0] fval;
    } regs_t;

    localparam regs_t ST_RST = '{en: EN_RESET, cnt: '0, fid: '0, fval: '0};

    regs_t st_d, st_q;
    logic  wr_page, rd_page;

    assign wr_page = (wr_addr[ADDR_W-1:4] == FLT_PAGE);
    assign rd_page = (rd_addr[ADDR_W-1:4] == FLT_PAGE);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == ADDR_EN) begin
                st_d.en = wr_data[NUM_FILT-1:0];
            end
            if (cfg_mode) begin
                if (wr_addr == ADDR_CNT) begin
                    st_d.cnt = wr_data[CNT_W-1:0];
                end
                for (int n = 0; n < NUM_FILT; n++) begin
                    if (wr_page && (wr_addr[3:0] == 4'(n))) begin
                        st_d.fid[n]  = wr_data[WIN_W+ID_W-1:WIN_W];
                        st_d.fval[n] = wr_data[WIN_W-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_eff = legacy_mode ? '0 : st_q.cnt;
    assign en_vec  = st_q.en;
    assign cnt_raw = st_q.cnt;
    assign fid     = st_q.fid;
    assign fval    = st_q.fval;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_EN) begin
            rd_data[NUM_FILT-1:0] = st_q.en;
        end else if (rd_addr == ADDR_CNT) begin
            rd_data[CNT_W-1:0] = cnt_eff;
        end else if (rd_page) begin
            for (int n = 0; n < NUM_FILT; n++) begin
                if (rd_addr[3:0] == 4'(n)) begin
                    rd_data[WIN_W+ID_W-1:0] = {st_q.fid[n], st_q.fval[n]};
                end
            end
        end
    end
endmodule

// File: rtl/cfl_len.sv
module cfl_len #(
    parameter int WIN_W = 18,
    parameter int CNT_W = 5,
    parameter int DLC_W = 4,
    parameter int LEN_W = 5
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [DLC_W-1:0] dlc,
    output logic [LEN_W-1:0] len
);
    int dlc_c;
    int cap;
    int req;

    always_comb begin
        dlc_c = (int'(dlc) > 3) ? 3 : int'(dlc);
        cap   = dlc_c * 8;
        if (cap > WIN_W) begin
            cap = WIN_W;
        end
        req = int'(cnt);
        if (req > cap) begin
            req = cap;
        end
        len = LEN_W'(req);
    end
endmodule

// File: rtl/cfl_match.sv
module cfl_match #(
    parameter int ID_W  = 11,
    parameter int WIN_W = 18,
    parameter int LEN_W = 5
) (
    input  logic             en,
    input  logic [ID_W-1:0]  id_in,
    input  logic [ID_W-1:0]  fid,
    input  logic [WIN_W-1:0] win,
    input  logic [LEN_W-1:0] len,
    input  logic [WIN_W-1:0] fval,
    output logic             hit
);
    int               sh;
    logic [WIN_W-1:0] aligned;
    logic [WIN_W:0]   mask_w;
    logic [WIN_W-1:0] diff;

    always_comb begin
        sh      = WIN_W - int'(len);
        aligned = win >> sh;
        mask_w  = ((WIN_W+1)'(1) << len) - (WIN_W+1)'(1);
        diff    = (aligned ^ fval) & mask_w[WIN_W-1:0];
        hit     = en && (id_in == fid) && (diff == '0);
    end
endmodule

// File: rtl/cfl_prio.sv
module cfl_prio #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/can_payload_filter_bank.sv
module can_payload_filter_bank
    import cfl_pkg::*;
#(
    parameter int NUM_FILT = 16,
    parameter int ID_W     = 11,
    parameter int WIN_W    = 18,
    parameter int CNT_W    = 5,
    parameter int DLC_W    = 4,
    parameter logic [NUM_FILT-1:0] EN_RESET = 16'h0003
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_mode,
    input  logic                            legacy_mode,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [DATA_W-1:0]               rd_data,
    input  logic                            frm_valid,
    input  logic [ID_W-1:0]                 frm_id,
    input  logic [DLC_W-1:0]                frm_dlc,
    input  logic [((WIN_W+7)/8)*8-1:0]      frm_data,
    output logic                            flt_hit,
    output logic [$clog2(NUM_FILT)-1:0]     flt_idx
);
    localparam int NBYTES = (WIN_W + 7) / 8;
    localparam int LEN_W  = $clog2(WIN_W + 1);
    localparam int IDX_W  = $clog2(NUM_FILT);

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } res_t;

    logic [NUM_FILT-1:0]              en_vec;
    logic [CNT_W-1:0]                 cnt_raw;
    logic [CNT_W-1:0]                 cnt_eff;
    logic [NUM_FILT-1:0][ID_W-1:0]    fid;
    logic [NUM_FILT-1:0][WIN_W-1:0]   fval;
    logic [LEN_W-1:0]                 eff_len;
    logic [WIN_W-1:0]                 win;
    logic [NUM_FILT-1:0]              hit_vec;
    logic                             any_hit;
    logic [IDX_W-1:0]                 low_idx;
    res_t                             res_d, res_q;

    cfl_regs #(
        .NUM_FILT (NUM_FILT),
        .ID_W     (ID_W),
        .WIN_W    (WIN_W),
        .CNT_W    (CNT_W),
        .EN_RESET (EN_RESET)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_mode    (cfg_mode),
        .legacy_mode (legacy_mode),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .en_vec      (en_vec),
        .cnt_raw     (cnt_raw),
        .cnt_eff     (cnt_eff),
        .fid         (fid),
        .fval        (fval)
    );

    cfl_len #(
        .WIN_W (WIN_W),
        .CNT_W (CNT_W),
        .DLC_W (DLC_W),
        .LEN_W (LEN_W)
    ) u_len (
        .cnt (cnt_eff),
        .dlc (frm_dlc),
        .len (eff_len)
    );

    assign win = frm_data[NBYTES*8-1 -: WIN_W];

    for (genvar g = 0; g < NUM_FILT; g++) begin : g_flt
        cfl_match #(
            .ID_W  (ID_W),
            .WIN_W (WIN_W),
            .LEN_W (LEN_W)
        ) u_match (
            .en    (en_vec[g]),
            .id_in (frm_id),
            .fid   (fid[g]),
            .win   (win),
            .len   (eff_len),
            .fval  (fval[g]),
            .hit   (hit_vec[g])
        );
    end

    cfl_prio #(
        .N     (NUM_FILT),
        .IDX_W (IDX_W)
    ) u_prio (
        .req (hit_vec),
        .any (any_hit),
        .idx (low_idx)
    );

    always_comb begin
        res_d = res_q;
        if (frm_valid) begin
            res_d.hit = any_hit;
            res_d.idx = any_hit ? low_idx : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign flt_hit = res_q.hit;
    assign flt_idx = res_q.idx;
endmodule

// File: rtl/cfl_chk.sv
module cfl_chk
    import cfl_pkg::*;
#(
    parameter int NUM_FILT = 16,
    parameter int WIN_W    = 18,
    parameter int CNT_W    = 5,
    parameter int DLC_W    = 4,
    parameter int LEN_W    = 5,
    parameter int IDX_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_mode,
    input logic                legacy_mode,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [DATA_W-1:0]   rd_data,
    input logic                frm_valid,
    input logic [DLC_W-1:0]    frm_dlc,
    input logic [NUM_FILT-1:0] en_vec,
    input logic [CNT_W-1:0]    cnt_raw,
    input logic [LEN_W-1:0]    eff_len,
    input logic                flt_hit,
    input logic [IDX_W-1:0]    flt_idx
);
    logic [NUM_FILT-1:0] en_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_prev <= '0;
        end else begin
            en_prev <= en_vec;
        end
    end

    p_dis_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> (!flt_hit || en_prev[flt_idx]));

    p_len_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(eff_len) <= WIN_W);

    p_dlc_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_dlc == '0) |-> (eff_len == '0));

    p_cnt_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == ADDR_CNT) |-> (rd_data[DATA_W-1:CNT_W] == '0));

    p_cnt_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && cfg_mode && (wr_addr == ADDR_CNT)) |=> $stable(cnt_raw));

    p_legacy_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_mode |-> (eff_len == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> ($stable(flt_hit) && $stable(flt_idx)));

    p_miss_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_hit |-> (flt_idx == '0));
endmodule

bind can_payload_filter_bank cfl_chk #(
    .NUM_FILT (NUM_FILT),
    .WIN_W    (WIN_W),
    .CNT_W    (CNT_W),
    .DLC_W    (DLC_W),
    .LEN_W    (LEN_W),
    .IDX_W    (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .legacy_mode (legacy_mode),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .frm_valid   (frm_valid),
    .frm_dlc     (frm_dlc),
    .en_vec      (en_vec),
    .cnt_raw     (cnt_raw),
    .eff_len     (eff_len),
    .flt_hit     (flt_hit),
    .flt_idx     (flt_idx)
);

// File: tb/can_payload_filter_bank_bench.sv
module can_payload_filter_bank_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [10:0] id;
        logic [3:0]  dlc;
        logic [23:0] data;
        logic        hit;
        logic [3:0]  idx;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{id: 11'h123, dlc: 4'd0, data: 24'h000000, hit: 1'b1, idx: 4'd0},
        '{id: 11'h123, dlc: 4'd1, data: 24'hAB0000, hit: 1'b1, idx: 4'd3},
        '{id: 11'h123, dlc: 4'd1, data: 24'hABFFFF, hit: 1'b1, idx: 4'd3},
        '{id: 11'h123, dlc: 4'd1, data: 24'hFF0000, hit: 1'b1, idx: 4'd0},
        '{id: 11'h123, dlc: 4'd2, data: 24'hAB0000, hit: 1'b0, idx: 4'd0},
        '{id: 11'h055, dlc: 4'd2, data: 24'hABCD00, hit: 1'b1, idx: 4'd9},
        '{id: 11'h055, dlc: 4'd3, data: 24'hABCD00, hit: 1'b0, idx: 4'd0},
        '{id: 11'h7FF, dlc: 4'd8, data: 24'h000000, hit: 1'b1, idx: 4'd7},
        '{id: 11'h7FF, dlc: 4'd8, data: 24'h000040, hit: 1'b0, idx: 4'd0},
        '{id: 11'h7FF, dlc: 4'd3, data: 24'h00003F, hit: 1'b1, idx: 4'd7},
        '{id: 11'h456, dlc: 4'd0, data: 24'h000000, hit: 1'b0, idx: 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_mode = 1'b0;
    logic        legacy_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        frm_valid = 1'b0;
    logic [10:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [23:0] frm_data = '0;
    logic        flt_hit;
    logic [3:0]  flt_idx;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_payload_filter_bank u_can_payload_filter_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_mode    (cfg_mode),
        .legacy_mode (legacy_mode),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .frm_valid   (frm_valid),
        .frm_id      (frm_id),
        .frm_dlc     (frm_dlc),
        .frm_data    (frm_data),
        .flt_hit     (flt_hit),
        .flt_idx     (flt_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic reg_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic send(input string req, input logic [10:0] id, input logic [3:0] dlc,
                        input logic [23:0] data, input logic eh, input logic [3:0] ei);
        @(negedge clk);
        frm_valid = 1'b1;
        frm_id    = id;
        frm_dlc   = dlc;
        frm_data  = data;
        @(negedge clk);
        frm_valid = 1'b0;
        chk({req, " hit"}, {31'd0, flt_hit}, {31'd0, eh});
        chk({req, " idx"}, {28'd0, flt_idx}, {28'd0, ei});
    endtask

    function automatic logic [31:0] fword(input logic [10:0] id, input logic [17:0] v);
        return {3'b000, id, v};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 / R1 / R5 / R6 reset state
        chk("R9 reset hit", {31'd0, flt_hit}, 32'd0);
        chk("R9 reset idx", {28'd0, flt_idx}, 32'd0);
        reg_chk("R1 enable reset", 6'h00, 32'h0000_0003);
        reg_chk("R5 count reset", 6'h01, 32'd0);
        reg_chk("R6 filter reset", 6'h17, 32'd0);

        // R6 writes ignored outside configuration mode
        reg_wr(6'h01, 32'd5);
        reg_chk("R6 count gated", 6'h01, 32'd0);
        reg_wr(6'h17, fword(11'h7FF, 18'h3FFFF));
        reg_chk("R6 filter gated", 6'h17, 32'd0);

        // R5 upper bits read as zero
        cfg_mode = 1'b1;
        reg_wr(6'h01, 32'hFFFF_FFFF);
        reg_chk("R5 count width", 6'h01, 32'h0000_001F);

        // configuration for the vector table
        reg_wr(6'h01, 32'd18);
        reg_wr(6'h10, fword(11'h123, 18'h3FFFF));
        reg_wr(6'h13, fword(11'h123, 18'h000AB));
        reg_wr(6'h17, fword(11'h7FF, 18'h00000));
        reg_wr(6'h19, fword(11'h055, 18'h0ABCD));
        cfg_mode = 1'b0;
        reg_wr(6'h00, 32'h0000_0289);
        reg_chk("R6 filter readback", 6'h19, fword(11'h055, 18'h0ABCD));

        // R2 R3 R4 R8 vector table
        for (int i = 0; i < NVEC; i++) begin
            send($sformatf("R4 vec%0d", i), VECS[i].id, VECS[i].dlc, VECS[i].data,
                 VECS[i].hit, VECS[i].idx);
        end

        // R8 hold when no strobe
        send("R8 hold setup", 11'h123, 4'd0, 24'h0, 1'b1, 4'd0);
        @(negedge clk);
        frm_id   = 11'h456;
        frm_data = 24'hFFFFFF;
        @(negedge clk);
        chk("R8 hold hit", {31'd0, flt_hit}, 32'd1);
        chk("R8 hold idx", {28'd0, flt_idx}, 32'd0);

        // R3 short count of 4
        cfg_mode = 1'b1;
        reg_wr(6'h01, 32'd4);
        cfg_mode = 1'b0;
        send("R3 count4 match", 11'h055, 4'd2, 24'hD00000, 1'b1, 4'd9);
        send("R3 count4 miss", 11'h055, 4'd2, 24'hA00000, 1'b0, 4'd0);

        // R3 count above 18 saturates
        cfg_mode = 1'b1;
        reg_wr(6'h01, 32'd31);
        cfg_mode = 1'b0;
        send("R3 sat miss", 11'h7FF, 4'd3, 24'h000040, 1'b0, 4'd0);
        send("R3 sat hit", 11'h7FF, 4'd3, 24'h00003F, 1'b1, 4'd7);

        // R7 legacy mode
        cfg_mode = 1'b1;
        reg_wr(6'h01, 32'd18);
        cfg_mode = 1'b0;
        legacy_mode = 1'b1;
        reg_chk("R7 legacy read", 6'h01, 32'd0);
        send("R7 legacy id only", 11'h123, 4'd1, 24'h000000, 1'b1, 4'd0);
        legacy_mode = 1'b0;
        reg_chk("R7 count restored", 6'h01, 32'd18);
        send("R7 legacy off", 11'h123, 4'd1, 24'h000000, 1'b0, 4'd0);

        // R1 enables
        reg_wr(6'h00, 32'h0000_0288);
        reg_chk("R1 enable write", 6'h00, 32'h0000_0288);
        send("R1 f0 disabled", 11'h123, 4'd0, 24'h0, 1'b1, 4'd3);
        reg_wr(6'h00, 32'h0000_0000);
        send("R1 all disabled", 11'h123, 4'd0, 24'h0, 1'b0, 4'd0);
        send("R1 all disabled 7", 11'h7FF, 4'd0, 24'h0, 1'b0, 4'd0);

        // R6 gated filter write leaves matching unchanged
        reg_wr(6'h00, 32'h0000_0080);
        reg_wr(6'h17, fword(11'h7FF, 18'h3FFFF));
        reg_chk("R6 gated keep", 6'h17, fword(11'h7FF, 18'h00000));
        send("R6 gated match", 11'h7FF, 4'd3, 24'h000000, 1'b1, 4'd7);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule